// File: doc/BRIEF.md
# Dual-Phase Serial Frame Receiver

This block deserializes a frame-synchronized serial stream whose frame is made of one or two phases. Each phase has its own word width and its own word count. When the second phase is enabled, the word width can change partway through a frame. All state advances on the falling edge of the serial clock `sclk`. A one-cycle `fsync` pulse that is sampled high marks the start of a frame. After a programmable delay of 0, 1 or 2 serial clocks, data bits follow MSB first.

Each completed word appears right-justified and zero-extended in a 32-bit output register. It comes with a one-cycle valid strobe, the phase it belongs to, its slot index inside that phase, and an end-of-frame marker on the last word. The frame layout is sampled from the configuration inputs only on the edge that starts a frame. Software can therefore reprogram the next frame while the current one is being received.

Top module: `dual_phase_frame_rx`

## Requirements
- R1: With `cfg_dual`=0 a frame is phase 0 only. With `cfg_dual`=1 it is phase 0 followed by phase 1, and `word_phase` reports 0 or 1 accordingly.
- R2: The word-width code maps 0→8, 1→12, 2→16, 3→20, 4→24 and 5→32 bits. Codes 6 and 7 also mean 32 bits. Phase 0 uses `cfg_wlen0` and phase 1 uses `cfg_wlen1`.
- R3: A count field holds the number of words minus one. A phase therefore carries 1 to 128 words, and `word_slot` runs from 0 up to the field value.
- R4: In a two-phase frame, the first bit of phase 1 is sampled on the edge right after the last bit of phase 0, with no gap.
- R5: With `cfg_delay`=d, the first data bit is sampled d falling edges after the edge that samples `fsync` high. For d=0 that is the same edge. A value of 3 behaves as 2.
- R6: Bits are shifted in MSB first on falling edges. `word_out` holds the word zero-extended to 32 bits. `word_valid` is high for exactly the one cycle after the word's last bit.
- R7: `frame_end` is high together with `word_valid` for the final word of the final phase. After that, data is ignored (no further `word_valid`) until the next `fsync`.
- R8: An `fsync` while a frame is still being received sets `sync_err` and restarts reception at phase 0, slot 0. `sync_err` stays set until reset. An `fsync` after `frame_end` is not an error.
- R9: Configuration changes made after the frame-start edge do not affect the current frame.
- R10: While `rx_rst_n` is 0 the receiver stays in reset: no `word_valid`, and `sync_err` is cleared. Setting `rx_rst_n` to 1 lets the next `fsync` start a frame.
- R11: `rst`, sampled on a falling edge, clears `word_out`, `word_valid`, `frame_end` and `sync_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial bit clock; all state updates on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| rx_rst_n | input | 1 | Receiver enable; 0 holds the receiver in reset |
| fsync | input | 1 | Frame-start pulse |
| sdin | input | 1 | Serial data, MSB first |
| cfg_dual | input | 1 | 0 = single-phase frame, 1 = two-phase frame |
| cfg_wlen0 | input | 3 | Word-width code for phase 0 |
| cfg_wlen1 | input | 3 | Word-width code for phase 1 |
| cfg_cnt0 | input | 7 | Word count minus one for phase 0 |
| cfg_cnt1 | input | 7 | Word count minus one for phase 1 |
| cfg_delay | input | 2 | Data delay in serial clocks after frame sync |
| word_out | output | 32 | Last received word, zero-extended |
| word_valid | output | 1 | One-cycle strobe for a new word |
| word_phase | output | 1 | Phase of the presented word |
| word_slot | output | 7 | Slot index of the presented word within its phase |
| frame_end | output | 1 | Marks the final word of the frame |
| sync_err | output | 1 | Sticky flag for a frame sync that arrived mid-frame |

## Verification
The bench aims at the phase boundary. A receiver that kept the phase-0 width, or that inserted or lost a bit there, would produce misaligned phase-1 words and shifted strobe timing. Each delay setting is exercised, including delay 0 where the sync edge itself carries the first bit; an off-by-one in the delay would move every word by one bit. Frames of 1 and of 128 words per phase probe the minus-one count encoding: a wrong compare drops or adds a word or misreports `frame_end`. A mid-frame sync, a mid-frame width change and data sent after the frame ends expose a receiver that fails to restart from slot 0, picks up the new configuration early, or keeps emitting words.

// File: rtl/dpfr_pkg.sv
package dpfr_pkg;
    localparam int WORD_W   = 32;
    localparam int SLOT_W   = 7;
    localparam int CODE_W   = 3;
    localparam int DLY_W    = 2;
    localparam int BITCNT_W = $clog2(WORD_W) + 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_DATA,
        ST_DONE
    } rx_state_e;

    typedef struct packed {
        logic              dual;
        logic [CODE_W-1:0] wl0;
        logic [CODE_W-1:0] wl1;
        logic [SLOT_W-1:0] n0;
        logic [SLOT_W-1:0] n1;
    } frame_cfg_t;

    function automatic logic [BITCNT_W-1:0] wlen_bits(input logic [CODE_W-1:0] code);
        case (code)
            3'd0:    return BITCNT_W'(8);
            3'd1:    return BITCNT_W'(12);
            3'd2:    return BITCNT_W'(16);
            3'd3:    return BITCNT_W'(20);
            3'd4:    return BITCNT_W'(24);
            default: return BITCNT_W'(32);
        endcase
    endfunction
endpackage

// File: rtl/dpfr_seq.sv
module dpfr_seq
    import dpfr_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  logic              fsync,
    input  frame_cfg_t        cfg_in,
    input  logic [DLY_W-1:0]  dly,
    output logic              take,
    output logic              restart,
    output logic              word_end,
    output logic              cur_phase,
    output logic [SLOT_W-1:0] cur_slot,
    output logic              last_word,
    output logic              sync_err
);
    rx_state_e               state_q;
    frame_cfg_t              cfg_q;
    logic                    phase_q;
    logic [SLOT_W-1:0]       slot_q;
    logic [BITCNT_W-1:0]     bitcnt_q;
    logic                    err_q;

    logic [BITCNT_W-1:0]     cur_len;
    logic [SLOT_W-1:0]       cur_cnt;
    logic                    last_phase;
    logic                    in_frame;

    always_comb begin
        cur_len    = wlen_bits(phase_q ? cfg_q.wl1 : cfg_q.wl0);
        cur_cnt    = phase_q ? cfg_q.n1 : cfg_q.n0;
        last_phase = !cfg_q.dual || phase_q;
        in_frame   = (state_q == ST_WAIT) || (state_q == ST_DATA);
        restart    = fsync;
        take       = fsync ? (dly == '0) : (state_q == ST_DATA);
        word_end   = !fsync && (state_q == ST_DATA) &&
                     (bitcnt_q == BITCNT_W'(cur_len - BITCNT_W'(1)));
        last_word  = word_end && last_phase && (slot_q == cur_cnt);
    end

    assign cur_phase = phase_q;
    assign cur_slot  = slot_q;
    assign sync_err  = err_q;

    always_ff @(negedge clk) begin
        if (clr) begin
            state_q  <= ST_IDLE;
            cfg_q    <= '0;
            phase_q  <= 1'b0;
            slot_q   <= '0;
            bitcnt_q <= '0;
            err_q    <= 1'b0;
        end else if (fsync) begin
            cfg_q    <= cfg_in;
            phase_q  <= 1'b0;
            slot_q   <= '0;
            bitcnt_q <= (dly == '0) ? BITCNT_W'(1) : '0;
            state_q  <= dly[1] ? ST_WAIT : ST_DATA;
            if (in_frame) err_q <= 1'b1;
        end else begin
            case (state_q)
                ST_WAIT: state_q <= ST_DATA;
                ST_DATA: begin
                    if (word_end) begin
                        bitcnt_q <= '0;
                        if (slot_q == cur_cnt) begin
                            if (last_phase) begin
                                state_q <= ST_DONE;
                            end else begin
                                phase_q <= 1'b1;
                                slot_q  <= '0;
                            end
                        end else begin
                            slot_q <= slot_q + SLOT_W'(1);
                        end
                    end else begin
                        bitcnt_q <= bitcnt_q + BITCNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // R2: the bit counter never reaches the active word width
    p_bitcnt_in_word_r2: assert property (@(negedge clk) disable iff (clr)
        (state_q == ST_DATA) |-> (bitcnt_q < cur_len));

    // R1: phase 1 is only entered for a two-phase frame
    p_phase1_needs_dual_r1: assert property (@(negedge clk) disable iff (clr)
        phase_q |-> cfg_q.dual);

    // R8: the error flag is sticky
    p_err_sticky_r8: assert property (@(negedge clk) disable iff (clr)
        err_q |=> err_q);

    // R8: a frame sync restarts at phase 0, slot 0
    p_restart_slot0_r8: assert property (@(negedge clk) disable iff (clr)
        fsync |=> (slot_q == '0) && !phase_q);
endmodule

// File: rtl/dpfr_deser.sv
module dpfr_deser
    import dpfr_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  logic              sdin,
    input  logic              take,
    input  logic              restart,
    input  logic              word_end,
    input  logic              cur_phase,
    input  logic [SLOT_W-1:0] cur_slot,
    input  logic              last_word,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid,
    output logic              word_phase,
    output logic [SLOT_W-1:0] word_slot,
    output logic              frame_end
);
    logic [WORD_W-1:0] sh_q;
    logic [WORD_W-1:0] sh_base;
    logic [WORD_W-1:0] sh_next;

    always_comb begin
        sh_base = restart ? '0 : sh_q;
        sh_next = {sh_base[WORD_W-2:0], sdin};
    end

    always_ff @(negedge clk) begin
        if (clr) begin
            sh_q       <= '0;
            word_out   <= '0;
            word_valid <= 1'b0;
            word_phase <= 1'b0;
            word_slot  <= '0;
            frame_end  <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            frame_end  <= 1'b0;
            if (restart) sh_q <= '0;
            if (take) begin
                if (word_end) begin
                    word_out   <= sh_next;
                    word_valid <= 1'b1;
                    word_phase <= cur_phase;
                    word_slot  <= cur_slot;
                    frame_end  <= last_word;
                    sh_q       <= '0;
                end else begin
                    sh_q <= sh_next;
                end
            end
        end
    end

    // R7: end of frame only accompanies a presented word
    p_eof_with_valid_r7: assert property (@(negedge clk) disable iff (clr)
        frame_end |-> word_valid);

    // R6: words are at least 8 bits, so strobes never come back to back
    p_valid_one_cycle_r6: assert property (@(negedge clk) disable iff (clr)
        word_valid |=> !word_valid);
endmodule

// File: rtl/dual_phase_frame_rx.sv
module dual_phase_frame_rx
    import dpfr_pkg::*;
(
    input  logic              sclk,
    input  logic              rst,
    input  logic              rx_rst_n,
    input  logic              fsync,
    input  logic              sdin,
    input  logic              cfg_dual,
    input  logic [2:0]        cfg_wlen0,
    input  logic [2:0]        cfg_wlen1,
    input  logic [6:0]        cfg_cnt0,
    input  logic [6:0]        cfg_cnt1,
    input  logic [1:0]        cfg_delay,
    output logic [31:0]       word_out,
    output logic              word_valid,
    output logic              word_phase,
    output logic [6:0]        word_slot,
    output logic              frame_end,
    output logic              sync_err
);
    logic              clr;
    frame_cfg_t        cfg;
    logic              take;
    logic              restart;
    logic              word_end;
    logic              cur_phase;
    logic [SLOT_W-1:0] cur_slot;
    logic              last_word;

    assign clr = rst || !rx_rst_n;
    assign cfg = '{dual: cfg_dual, wl0: cfg_wlen0, wl1: cfg_wlen1,
                   n0: cfg_cnt0, n1: cfg_cnt1};

    dpfr_seq u_seq (
        .clk       (sclk),
        .clr       (clr),
        .fsync     (fsync),
        .cfg_in    (cfg),
        .dly       (cfg_delay),
        .take      (take),
        .restart   (restart),
        .word_end  (word_end),
        .cur_phase (cur_phase),
        .cur_slot  (cur_slot),
        .last_word (last_word),
        .sync_err  (sync_err)
    );

    dpfr_deser u_deser (
        .clk        (sclk),
        .clr        (clr),
        .sdin       (sdin),
        .take       (take),
        .restart    (restart),
        .word_end   (word_end),
        .cur_phase  (cur_phase),
        .cur_slot   (cur_slot),
        .last_word  (last_word),
        .word_out   (word_out),
        .word_valid (word_valid),
        .word_phase (word_phase),
        .word_slot  (word_slot),
        .frame_end  (frame_end)
    );

    // R10: a held receiver presents nothing and reports no error
    p_hold_quiet_r10: assert property (@(negedge sclk) disable iff (rst)
        !rx_rst_n |=> (!word_valid && !sync_err));
endmodule

// File: tb/dual_phase_frame_rx_test.sv
`timescale 1ns/1ps
module dual_phase_frame_rx_test;
    logic        sclk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_rst_n = 1'b1;
    logic        fsync = 1'b0;
    logic        sdin = 1'b0;
    logic        cfg_dual = 1'b0;
    logic [2:0]  cfg_wlen0 = '0;
    logic [2:0]  cfg_wlen1 = '0;
    logic [6:0]  cfg_cnt0 = '0;
    logic [6:0]  cfg_cnt1 = '0;
    logic [1:0]  cfg_delay = '0;
    logic [31:0] word_out;
    logic        word_valid;
    logic        word_phase;
    logic [6:0]  word_slot;
    logic        frame_end;
    logic        sync_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 sclk = ~sclk;

    dual_phase_frame_rx uut (.*);

    // {dual, wlen0, wlen1, cnt0, cnt1, delay}
    localparam int NV = 6;
    localparam logic [22:0] VEC [NV] = '{
        {1'b0, 3'd0, 3'd0, 7'd3, 7'd0, 2'd1},
        {1'b1, 3'd1, 3'd3, 7'd1, 7'd2, 2'd0},
        {1'b1, 3'd5, 3'd2, 7'd0, 7'd0, 2'd2},
        {1'b0, 3'd4, 3'd0, 7'd0, 7'd0, 2'd1},
        {1'b1, 3'd6, 3'd7, 7'd1, 7'd0, 2'd2},
        {1'b0, 3'd2, 3'd0, 7'd2, 7'd0, 2'd3}
    };

    logic [31:0] ew [256];
    int          et [256];
    int          ebase [256];
    int          ewid [256];
    logic        ep [256];
    logic [6:0]  es [256];
    logic        ee [256];

    function automatic int width_of(input logic [2:0] c);
        case (c)
            3'd0: return 8;
            3'd1: return 12;
            3'd2: return 16;
            3'd3: return 20;
            3'd4: return 24;
            default: return 32;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic fs, input logic d);
        @(posedge sclk);
        fsync <= fs;
        sdin  <= d;
        @(negedge sclk);
        #1;
    endtask

    task automatic run_frame(input logic [22:0] v, input int seed, input bit flip, input string tag);
        logic       dual = v[22];
        logic [2:0] c0 = v[21:19];
        logic [2:0] c1 = v[18:16];
        logic [6:0] n0 = v[15:9];
        logic [6:0] n1 = v[8:2];
        int dly = (v[1:0] == 2'd3) ? 2 : int'(v[1:0]);
        int nw = 0;
        int cum = 0;
        int k2 = 0;
        int total;
        for (int p = 0; p <= (dual ? 1 : 0); p++) begin
            int w = width_of(p == 0 ? c0 : c1);
            int n = (p == 0) ? int'(n0) : int'(n1);
            for (int s = 0; s <= n; s++) begin
                logic [31:0] raw = (32'(seed) * 32'h9E3779B1) ^ (32'(nw + 1) * 32'h7F4A7C15);
                raw = raw ^ {raw[15:0], raw[31:16]};
                ew[nw]    = (w == 32) ? raw : (raw & ((32'd1 << w) - 32'd1));
                ebase[nw] = cum;
                ewid[nw]  = w;
                cum      += w;
                et[nw]    = dly + cum - 1;
                ep[nw]    = 1'(p);
                es[nw]    = 7'(s);
                ee[nw]    = 1'b0;
                nw++;
            end
        end
        ee[nw-1] = 1'b1;
        total = dly + cum;
        cfg_dual = dual; cfg_wlen0 = c0; cfg_wlen1 = c1;
        cfg_cnt0 = n0; cfg_cnt1 = n1; cfg_delay = v[1:0];
        for (int t = 0; t < total + 40; t++) begin
            int i = t - dly;
            logic b = 1'b1;
            bit expv;
            if (i >= 0 && i < cum) begin
                for (int k = 0; k < nw; k++)
                    if (i >= ebase[k] && i < ebase[k] + ewid[k])
                        b = ew[k][ewid[k] - 1 - (i - ebase[k])];
            end
            tick(t == 0, b);
            if (flip && t == 0) begin
                cfg_wlen0 = c0 ^ 3'd1;
                cfg_wlen1 = c1 ^ 3'd2;
                cfg_cnt0  = n0 + 7'd1;
                cfg_dual  = ~dual;
            end
            expv = (k2 < nw) && (t == et[k2]);
            if (word_valid !== expv) begin
                chk(0, $sformatf("%s R6/R4/R5/R7 strobe timing at tick %0d", tag, t),
                    64'(word_valid), 64'(expv));
            end else if (expv) begin
                chk({frame_end, word_phase, word_slot, word_out} === {ee[k2], ep[k2], es[k2], ew[k2]},
                    $sformatf("%s R1/R2/R3/R6/R7 word %0d {eof,phase,slot,data}", tag, k2),
                    {23'd0, frame_end, word_phase, word_slot, word_out},
                    {23'd0, ee[k2], ep[k2], es[k2], ew[k2]});
                k2++;
            end
        end
        chk(k2 == nw, {tag, " R3/R7 words per frame"}, 64'(k2), 64'(nw));
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        repeat (3) tick(1'b0, 1'b1);
        chk({word_valid, frame_end, sync_err, word_out} === 35'd0, "R11 reset state",
            64'({word_valid, frame_end, sync_err, word_out}), 64'd0);
        rst = 1'b0;

        // table of frame layouts
        for (int v = 0; v < NV; v++)
            run_frame(VEC[v], v + 11, 1'b0, $sformatf("vec%0d", v));
        // R8: frame sync after frame end is no error
        chk(sync_err === 1'b0, "R8 no error after clean frames", 64'(sync_err), 64'd0);

        // R3: 128 words in each phase
        run_frame({1'b1, 3'd0, 3'd0, 7'd127, 7'd127, 2'd1}, 99, 1'b0, "max128");

        // R9: configuration changed right after frame start
        run_frame({1'b1, 3'd1, 3'd4, 7'd2, 7'd1, 2'd0}, 41, 1'b1, "R9 midcfg");

        // R8: sync during a frame aborts and restarts at slot 0
        cfg_dual = 1'b0; cfg_wlen0 = 3'd0; cfg_cnt0 = 7'd3; cfg_delay = 2'd1;
        tick(1'b1, 1'b0);
        for (int i = 0; i < 12; i++) tick(1'b0, 1'b1);
        chk(sync_err === 1'b0, "R8 no error before abort", 64'(sync_err), 64'd0);
        run_frame(VEC[0], 57, 1'b0, "R8 restart");
        chk(sync_err === 1'b1, "R8 error flag set by mid-frame sync", 64'(sync_err), 64'd1);
        run_frame(VEC[3], 63, 1'b0, "R8 sticky");
        chk(sync_err === 1'b1, "R8 error flag sticky", 64'(sync_err), 64'd1);

        // R10: receiver held in reset
        rx_rst_n = 1'b0;
        begin
            int seen = 0;
            for (int i = 0; i < 60; i++) begin
                tick((i % 20) == 0, 1'(i & 1));
                if (word_valid) seen++;
            end
            chk(seen == 0, "R10 no words while held", 64'(seen), 64'd0);
        end
        chk(sync_err === 1'b0, "R10 error cleared while held", 64'(sync_err), 64'd0);
        rx_rst_n = 1'b1;
        run_frame(VEC[1], 77, 1'b0, "R10 released");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule